// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a real-time clock core that sits on a simple 32-bit register bus. A slow clock enable at 32.768 kHz arrives as a one-cycle pulse in the bus clock domain. The core divides it down to a one-second tick. The tick advances a 32-bit seconds count. An alarm comparator and two sticky event flags feed a single interrupt line.

Register writes are modelled as if they must travel into the slow domain. An accepted write is held in a one-entry transfer stage and lands only on a later slow enable pulse. A ready bit in the control register is low for that whole time. Software polls the ready bit before it writes again.

A parameter can turn on write protection. With protection on, every write to a clocked register must follow an unlock write of a fixed key to the unlock register. A scratch register keeps one word for software.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, control reads 0x0000_0080 (only ready set), and seconds, alarm, scratch and unlock read 0. The interrupt output is low.
- R2: Register offsets are 0x00 control, 0x04 seconds, 0x08 alarm, 0x34 scratch and 0x3C unlock. Any other offset reads 0. Read data is combinational from the address.
- R3: Control bit positions are 7 ready (read-only), 6 tick flag, 5 tick interrupt enable, 4 alarm flag, 3 alarm interrupt enable, 2 alarm enable and 0 count enable. Bit 1 and bits 31:8 read 0.
- R4: An accepted write drops ready in the next cycle. The write lands on the WR_LAT-th slow enable pulse after acceptance, and ready returns at the same moment. A write to control, seconds, alarm or scratch issued while ready is low is dropped.
- R5: With protection on, writing exactly 0x0000_A55A to 0x3C sets unlock bit 31 at once. Any other value written there leaves the unlock register unchanged.
- R6: With protection on, a write to control, seconds, alarm or scratch is accepted only while unlock bit 31 is set, and acceptance clears that bit. Without unlock the write is ignored and ready stays high.
- R7: While count enable is 1, seconds increments once every TICKS_PER_SEC slow enable pulses. While it is 0, seconds and the divider hold. A landed seconds write loads the value directly and takes priority over a tick in the same cycle.
- R8: Each one-second tick sets the tick flag.
- R9: A landed control write clears a flag whose data bit is 0 and keeps a flag whose data bit is 1. A flag-setting event in the same cycle wins over the clear.
- R10: The alarm flag sets when a tick steps seconds onto the alarm value while alarm enable is 1. With alarm enable 0 it does not set.
- R11: The interrupt output is high exactly when (tick flag AND tick interrupt enable) OR (alarm flag AND alarm interrupt enable).
- R12: Two back-to-back seconds reads that return the same value give the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_en_i | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write strobe, qualified by req_i |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the core with protection on, TICKS_PER_SEC of 4 and WR_LAT of 3. It pulses the slow enable every fourth bus cycle. A simulated second then lasts 16 bus cycles, so many ticks, alarm matches and flag races fall inside a short run. The 3-pulse write latency leaves a window of about a dozen cycles in which a second write can be issued and shown to be dropped. The same small divider makes a tick and a landed control write meet on one edge often enough to exercise the event-wins rule.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SEC     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_ALARM   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SCRATCH = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_UNLOCK  = 8'h3C;

  localparam int unsigned B_READY = 7;
  localparam int unsigned B_TFLG  = 6;
  localparam int unsigned B_TIE   = 5;
  localparam int unsigned B_AFLG  = 4;
  localparam int unsigned B_AIE   = 3;
  localparam int unsigned B_AEN   = 2;
  localparam int unsigned B_CEN   = 0;
  localparam int unsigned B_ULK   = 31;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A55A;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_SEC,
    TGT_ALARM,
    TGT_SCRATCH
  } tgt_e;

  function automatic tgt_e decode_tgt(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CTRL:    decode_tgt = TGT_CTRL;
      OFF_SEC:     decode_tgt = TGT_SEC;
      OFF_ALARM:   decode_tgt = TGT_ALARM;
      OFF_SCRATCH: decode_tgt = TGT_SCRATCH;
      default:     decode_tgt = TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wr_xfer.sv
module rtc_wr_xfer
  import rtc_pkg::*;
#(
  parameter int unsigned WR_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              accept_i,
  input  tgt_e              tgt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              commit_o,
  output tgt_e              cm_tgt_o,
  output logic [DATA_W-1:0] cm_data_o
);
  localparam int unsigned CNT_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_LAT - 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  tgt_e              tgt_q;
  logic [DATA_W-1:0] data_q;

  assign ready_o   = ~busy_q;
  assign commit_o  = busy_q & slow_en_i & (cnt_q == LAST);
  assign cm_tgt_o  = tgt_q;
  assign cm_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= TGT_NONE;
      data_q <= '0;
    end else if (accept_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      tgt_q  <= tgt_i;
      data_q <= data_i;
    end else if (busy_q && slow_en_i) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic slow_en_i,
  output logic tick_o
);
  generate
    if (TICKS_PER_SEC <= 1) begin : g_pass
      assign tick_o = en_i & slow_en_i;
    end else begin : g_div
      localparam int unsigned CNT_W = $clog2(TICKS_PER_SEC);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);
      logic [CNT_W-1:0] cnt_q;
      logic             wrap;

      assign wrap   = cnt_q == LAST;
      assign tick_o = en_i & slow_en_i & wrap;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               cnt_q <= '0;
        else if (en_i && slow_en_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  // event wins over a write-0 clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~(wr_i & ~wbit_i));
  end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
#(
  parameter bit          PROTECT_EN    = 1'b1,
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned WR_LAT        = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  tgt_e              wr_tgt;
  logic              bus_wr;
  logic              wr_ready;
  logic              wr_accept;
  logic              wr_commit;
  tgt_e              cm_tgt;
  logic [DATA_W-1:0] cm_data;
  logic              wen_q;
  logic              tick;
  logic              alarm_evt;
  logic [DATA_W-1:0] sec_next;

  logic [DATA_W-1:0] sec_q, alarm_q, scratch_q;
  logic              ce_q, ae_q, aie_q, tie_q;
  logic              tflg_q, aflg_q;
  logic              cm_ctrl, cm_sec, cm_alarm, cm_scratch;

  assign wr_tgt = decode_tgt(addr_i);
  assign bus_wr = req_i & we_i;

  generate
    if (PROTECT_EN) begin : g_prot
      logic key_wr;
      assign key_wr    = bus_wr & (addr_i == OFF_UNLOCK) & (wdata_i == UNLOCK_KEY);
      assign wr_accept = bus_wr & (wr_tgt != TGT_NONE) & wr_ready & wen_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        wen_q <= 1'b0;
        else if (wr_accept) wen_q <= 1'b0;
        else if (key_wr)    wen_q <= 1'b1;
      end
    end else begin : g_open
      assign wr_accept = bus_wr & (wr_tgt != TGT_NONE) & wr_ready;
      assign wen_q     = 1'b0;
    end
  endgenerate

  rtc_wr_xfer #(.WR_LAT(WR_LAT)) u_xfer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slow_en_i (slow_en_i),
    .accept_i  (wr_accept),
    .tgt_i     (wr_tgt),
    .data_i    (wdata_i),
    .ready_o   (wr_ready),
    .commit_o  (wr_commit),
    .cm_tgt_o  (cm_tgt),
    .cm_data_o (cm_data)
  );

  rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ce_q),
    .slow_en_i (slow_en_i),
    .tick_o    (tick)
  );

  assign cm_ctrl    = wr_commit & (cm_tgt == TGT_CTRL);
  assign cm_sec     = wr_commit & (cm_tgt == TGT_SEC);
  assign cm_alarm   = wr_commit & (cm_tgt == TGT_ALARM);
  assign cm_scratch = wr_commit & (cm_tgt == TGT_SCRATCH);

  assign sec_next  = sec_q + 1'b1;
  assign alarm_evt = tick & ae_q & (sec_next == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q     <= '0;
      alarm_q   <= '0;
      scratch_q <= '0;
      ce_q      <= 1'b0;
      ae_q      <= 1'b0;
      aie_q     <= 1'b0;
      tie_q     <= 1'b0;
    end else begin
      if (cm_sec)      sec_q <= cm_data;
      else if (tick)   sec_q <= sec_next;
      if (cm_alarm)    alarm_q   <= cm_data;
      if (cm_scratch)  scratch_q <= cm_data;
      if (cm_ctrl) begin
        ce_q  <= cm_data[B_CEN];
        ae_q  <= cm_data[B_AEN];
        aie_q <= cm_data[B_AIE];
        tie_q <= cm_data[B_TIE];
      end
    end
  end

  rtc_evt_flag u_tflg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tick),
    .wr_i   (cm_ctrl),
    .wbit_i (cm_data[B_TFLG]),
    .flag_o (tflg_q)
  );

  rtc_evt_flag u_aflg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (alarm_evt),
    .wr_i   (cm_ctrl),
    .wbit_i (cm_data[B_AFLG]),
    .flag_o (aflg_q)
  );

  assign irq_o = (tflg_q & tie_q) | (aflg_q & aie_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: begin
        rdata_o[B_READY] = wr_ready;
        rdata_o[B_TFLG]  = tflg_q;
        rdata_o[B_TIE]   = tie_q;
        rdata_o[B_AFLG]  = aflg_q;
        rdata_o[B_AIE]   = aie_q;
        rdata_o[B_AEN]   = ae_q;
        rdata_o[B_CEN]   = ce_q;
      end
      OFF_SEC:     rdata_o = sec_q;
      OFF_ALARM:   rdata_o = alarm_q;
      OFF_SCRATCH: rdata_o = scratch_q;
      OFF_UNLOCK:  rdata_o[B_ULK] = wen_q;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_accept,
  input logic        wr_ready,
  input logic        wr_commit,
  input logic        tick,
  input logic        ce_q,
  input logic        ae_q,
  input logic [31:0] sec_q,
  input logic [31:0] alarm_q,
  input logic        tflg_q,
  input logic        aflg_q,
  input logic        wen_q
);
  // R4
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_accept |=> !wr_ready);

  // R6
  unlock_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_accept |=> !wen_q);

  // R7
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_q && !wr_commit) |=> $stable(sec_q));

  // R8
  tick_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> tflg_q);

  // R9
  tflag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tflg_q && !wr_commit) |=> tflg_q);

  // R10
  alarm_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ae_q && (sec_q + 32'd1 == alarm_q)) |=> aflg_q);
endmodule

bind rtc_sec_core rtc_sec_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_accept (wr_accept),
  .wr_ready  (wr_ready),
  .wr_commit (wr_commit),
  .tick      (tick),
  .ce_q      (ce_q),
  .ae_q      (ae_q),
  .sec_q     (sec_q),
  .alarm_q   (alarm_q),
  .tflg_q    (tflg_q),
  .aflg_q    (aflg_q),
  .wen_q     (wen_q)
);

// File: tb/rtc_sec_core_bench.sv
module rtc_sec_core_bench;
  localparam int TPS = 4;
  localparam int WRL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_sec_core #(.PROTECT_EN(1'b1), .TICKS_PER_SEC(TPS), .WR_LAT(WRL)) u_rtc_sec_core (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // slow enable: one pulse every fourth cycle, driven away from the edge
  int div_cnt = 0;
  always @(negedge clk) begin
    div_cnt = (div_cnt + 1) % 4;
    slow_en = (div_cnt == 0);
  end

  // behavioural reference model
  logic [31:0] m_sec, m_alarm, m_scr, m_pd;
  logic [7:0]  m_pa;
  bit m_ce, m_ae, m_aie, m_tie, m_tf, m_af, m_busy, m_wen;
  int m_pre, m_scnt;
  bit t_tk, t_cm, t_acc, t_aev, t_tgt, t_cc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_alarm = 0; m_scr = 0; m_pd = 0; m_pa = 0;
      m_ce = 0; m_ae = 0; m_aie = 0; m_tie = 0; m_tf = 0; m_af = 0;
      m_busy = 0; m_wen = 0; m_pre = 0; m_scnt = 0;
    end else begin
      t_tk  = m_ce && slow_en && (m_pre == TPS - 1);
      t_cm  = m_busy && slow_en && (m_scnt == WRL - 1);
      t_tgt = (addr == 8'h00) || (addr == 8'h04) || (addr == 8'h08) || (addr == 8'h34);
      t_acc = req && we && t_tgt && !m_busy && m_wen;
      t_aev = t_tk && m_ae && (m_sec + 1 == m_alarm);
      t_cc  = t_cm && (m_pa == 8'h00);
      if (m_ce && slow_en) m_pre = t_tk ? 0 : m_pre + 1;
      m_tf = t_tk  || (m_tf && !(t_cc && !m_pd[6]));
      m_af = t_aev || (m_af && !(t_cc && !m_pd[4]));
      if (t_cm && m_pa == 8'h04) m_sec = m_pd;
      else if (t_tk) m_sec = m_sec + 1;
      if (t_cm && m_pa == 8'h08) m_alarm = m_pd;
      if (t_cm && m_pa == 8'h34) m_scr = m_pd;
      if (t_cc) begin
        m_ce = m_pd[0]; m_ae = m_pd[2]; m_aie = m_pd[3]; m_tie = m_pd[5];
      end
      if (t_acc) begin
        m_busy = 1; m_scnt = 0; m_pa = addr; m_pd = wdata;
      end else if (m_busy && slow_en) begin
        if (m_scnt == WRL - 1) m_busy = 0;
        else m_scnt = m_scnt + 1;
      end
      if (t_acc) m_wen = 0;
      else if (req && we && addr == 8'h3C && wdata == 32'h0000_A55A) m_wen = 1;
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: mread = {24'd0, !m_busy, m_tf, m_tie, m_af, m_aie, m_ae, 1'b0, m_ce};
      8'h04: mread = m_sec;
      8'h08: mread = m_alarm;
      8'h34: mread = m_scr;
      8'h3C: mread = {m_wen, 31'd0};
      default: mread = 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #6;
    if (rst_n && !done) begin
      chk("R2 R3 per-cycle read", rdata, mread(addr));
      chk("R11 per-cycle irq", {31'd0, irq}, {31'd0, (m_tf && m_tie) || (m_af && m_aie)});
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; wdata = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] c;
    for (int i = 0; i < 100; i++) begin
      bus_rd(8'h00, c);
      if (c[7]) break;
    end
  endtask

  task automatic prot_wr(input logic [7:0] a, input logic [31:0] d);
    wait_ready();
    bus_wr(8'h3C, 32'h0000_A55A);
    bus_wr(a, d);
  endtask

  // R12: repeat reads until two back-to-back agree
  task automatic read_sec(output logic [31:0] s);
    logic [31:0] a, b;
    bus_rd(8'h04, a);
    bus_rd(8'h04, b);
    for (int i = 0; i < 5 && a != b; i++) begin
      a = b;
      bus_rd(8'h04, b);
    end
    s = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, s1, s2;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(8'h00, v); chk("R1 ctrl reset", v, 32'h0000_0080);
    bus_rd(8'h04, v); chk("R1 seconds reset", v, 0);
    bus_rd(8'h08, v); chk("R1 alarm reset", v, 0);
    bus_rd(8'h34, v); chk("R1 scratch reset", v, 0);
    bus_rd(8'h3C, v); chk("R1 unlock reset", v, 0);
    chk("R1 irq reset", {31'd0, irq}, 0);
    bus_rd(8'h10, v); chk("R2 unmapped offset", v, 0);

    // R6 write without unlock is ignored
    bus_wr(8'h34, 32'h1234_5678);
    bus_rd(8'h00, v); chk("R6 ready stays high", v, 32'h0000_0080);
    repeat (20) @(negedge clk);
    bus_rd(8'h34, v); chk("R6 locked write ignored", v, 0);

    // R5 unlock key
    bus_wr(8'h3C, 32'h0000_1234);
    bus_rd(8'h3C, v); chk("R5 wrong key ignored", v, 0);
    bus_wr(8'h3C, 32'h0000_A55A);
    bus_rd(8'h3C, v); chk("R5 key sets unlock", v, 32'h8000_0000);

    // R4 R6 accepted write, busy window, landing
    bus_wr(8'h34, 32'hCAFE_F00D);
    bus_rd(8'h3C, v); chk("R6 unlock consumed", v, 0);
    bus_rd(8'h00, v); chk("R4 ready low while busy", v, 32'h0000_0000);
    bus_rd(8'h34, v); chk("R4 not landed yet", v, 0);
    wait_ready();
    bus_rd(8'h34, v); chk("R4 scratch landed", v, 32'hCAFE_F00D);

    // R4 write during busy is dropped
    prot_wr(8'h34, 32'h1111_1111);
    bus_wr(8'h3C, 32'h0000_A55A);
    bus_wr(8'h08, 32'h0000_0055);
    bus_rd(8'h3C, v); chk("R4 dropped write keeps unlock", v, 32'h8000_0000);
    wait_ready();
    bus_rd(8'h08, v); chk("R4 busy write dropped", v, 0);
    bus_rd(8'h34, v); chk("R4 first write landed", v, 32'h1111_1111);

    // R7 R12 counting
    prot_wr(8'h04, 32'd100);
    prot_wr(8'h00, 32'h0000_0001);
    wait_ready();
    read_sec(s1); chk("R12 stable read matches count", s1, m_sec);
    repeat (64) @(negedge clk);
    read_sec(s2); chk("R7 R12 count advanced", s2, m_sec);
    chk("R7 count moved forward", {31'd0, s2 > s1}, 1);
    bus_rd(8'h00, v); chk("R8 tick flag set", v & 32'h40, 32'h40);

    // R9 write 1 keeps flag; R7 hold while disabled
    prot_wr(8'h00, 32'h0000_0040);
    wait_ready();
    read_sec(s1);
    repeat (48) @(negedge clk);
    read_sec(s2); chk("R7 hold while disabled", s2, s1);
    bus_rd(8'h00, v); chk("R9 write-1 keeps flag", v, 32'h0000_00C0);
    prot_wr(8'h00, 32'h0000_0000);
    wait_ready();
    bus_rd(8'h00, v); chk("R9 write-0 clears flag", v, 32'h0000_0080);

    // R11 tick interrupt
    prot_wr(8'h00, 32'h0000_0020);
    wait_ready();
    bus_rd(8'h00, v); chk("R3 tick irq enable bit", v, 32'h0000_00A0);
    chk("R11 irq low without flag", {31'd0, irq}, 0);
    prot_wr(8'h00, 32'h0000_0021);
    for (int i = 0; i < 100; i++) begin
      bus_rd(8'h00, v);
      if (v[6]) break;
    end
    chk("R8 flag after enable", v & 32'h40, 32'h40);
    chk("R11 irq from tick flag", {31'd0, irq}, 1);

    // R10 alarm match
    prot_wr(8'h00, 32'h0000_0000);
    prot_wr(8'h04, 32'd200);
    prot_wr(8'h08, 32'd202);
    prot_wr(8'h00, 32'h0000_000D);
    for (int i = 0; i < 200; i++) begin
      bus_rd(8'h00, v);
      if (v[4]) break;
    end
    chk("R10 alarm flag set", v & 32'h10, 32'h10);
    read_sec(s1); chk("R10 R12 count at alarm", s1, 32'd202);
    chk("R11 irq from alarm flag", {31'd0, irq}, 1);

    // R10 no match when alarm disabled
    prot_wr(8'h00, 32'h0000_0008);
    prot_wr(8'h04, 32'd300);
    prot_wr(8'h08, 32'd301);
    prot_wr(8'h00, 32'h0000_0009);
    wait_ready();
    repeat (40) @(negedge clk);
    bus_rd(8'h00, v); chk("R10 disabled alarm no flag", v & 32'h10, 0);
    chk("R11 irq low, no enabled flag", {31'd0, irq}, 0);
    read_sec(s1); chk("R7 R12 passed alarm value", {31'd0, s1 > 32'd301}, 1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule